// File: doc/BRIEF.md
# MDIO Management Master

This block is a memory-mapped master for the two-wire station management bus that links a MAC to its PHYs. Software fills a parameter word and an address word, then writes an operation code to the control register. The block serialises one management transaction on MDC/MDIO. A Clause 22 transaction is a single frame. A Clause 45 transaction is an address frame followed by a data frame. When a read finishes, the 16 bits the PHY returned go into a read-data register, and a done flag is set in the status register. Writing zero to the control register clears the flag and makes the block idle again.

The MDC rate comes from a divisor and a dividend held in one of two rate registers. The parameter word chooses which register applies, through the same bit that routes the transaction to the internal or the external bus. The parameter word also carries a bus index, which the block drives out to the bus steering logic. A separate scan-control bit is driven out so that the surroundings can lock out a second, external master.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset, reads return these values: 0x0001_0002 from the external rate register (0x000) and from the internal rate register (0x004); zero from scan control (0x008), parameter (0x23C), read data (0x240), address (0x244), control (0x248) and status (0x24C).
- R2: Parameter bit 25 drives `bus_int`, parameter bits 24:22 drive `bus_idx`, and scan-control bit 28 drives `ext_block`. Each of these values reads back from its register.
- R3: Writing 1 to control starts a write transaction and writing 2 starts a read. Any other nonzero value is ignored, and so is any start written while an operation is running or while done is still set. An ignored write leaves MDC low and the status unchanged.
- R4: Parameter bit 21 = 0 selects a Clause 22 frame. It is 32 ones, start 01, opcode 01 for a write or 10 for a read, the PHY address from parameter bits 20:16, the register address from address bits 4:0, turnaround 1 then 0, and then the 16 data bits from parameter bits 15:0, all sent MSB first.
- R5: Parameter bit 21 = 1 selects Clause 45. The block first sends an address frame (start 00, opcode 00) whose device field is address bits 20:16 and whose data field is address bits 15:0. It then sends a data frame with opcode 01 for a write or 11 for a read, using the same device field. Each frame has a 32-bit preamble, and there is no gap between the two frames.
- R6: The MDC period is D × (V + 1) core cycles. D is the divisor in bits 7:0 and V is the dividend in bits 19:16 of the rate register that parameter bit 25 selects (1 = internal). D = 0 counts as 1, and a period below 2 is raised to 2. MDC is low for the first floor(period/2) cycles of every bit. The period is latched when the transaction starts.
- R7: MDIO changes only when MDC falls. While MDC is high, `mdio_o` and `mdio_oe` hold their values.
- R8: On the final frame of a read, `mdio_oe` is low from the second turnaround bit through the last data bit. Outside a transaction, both MDC and `mdio_oe` stay low.
- R9: During a read, the block samples `mdio_i` on each rising MDC edge of the 16 data bits, MSB first. The result appears in bits 15:0 of the read-data register once done is set.
- R10: Status bit 0 reads 1 once the last frame has ended. A write of 0 to control clears it, and if a transaction is running, the same write stops MDC and releases MDIO on the next edge.
- R11: Writes to the parameter and address registers are dropped while a transaction is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational on reg_addr |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO value to drive |
| mdio_oe | output | 1 | MDIO drive enable |
| mdio_i | input | 1 | MDIO value sensed on the pin |
| bus_int | output | 1 | 1 routes the transaction to the internal bus |
| bus_idx | output | 3 | Bus index within the selected group |
| ext_block | output | 1 | Locks out an external master |

## Verification
The bench steps through an odd period (3), the clamped minimum period (divisor 0), and a period built from the dividend (4). A divider that dropped the clamp or rounded the low phase the wrong way would fail the period and high-time checks at every MDC edge. Read data of 0xA5C3, 0x1234 and 0x0001 catch a reversed bit order or a sample taken on the wrong edge. Clause 45 runs check the zero-gap handoff between the two frames, which breaks if the bit counter is off by one at the seam. The bench also tries a start while done is set, an opcode of 3, parameter and address writes during a run, and an abort in mid-frame; a design that ignored the gating would restart the bus or send altered fields.

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master #(
  parameter int DIV_W = 8,
  parameter int DVD_W = 4,
  parameter logic [31:0] RATE_RST = 32'h0001_0002
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [11:0] reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i,
  output logic        bus_int,
  output logic [2:0]  bus_idx,
  output logic        ext_block
);
  localparam int CNT_W = DIV_W + DVD_W + 1;
  localparam logic [11:0] A_RATE_EXT = 12'h000, A_RATE_INT = 12'h004, A_SCAN = 12'h008,
                          A_PARAM = 12'h23C, A_RDATA = 12'h240, A_ADDR = 12'h244,
                          A_CTRL = 12'h248, A_STAT = 12'h24C;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_DONE} st_t;

  st_t              st;
  logic [DIV_W-1:0] div_ext, div_int;
  logic [DVD_W-1:0] dvd_ext, dvd_int;
  logic             scan_ovr;
  logic [25:0]      param_q;
  logic [20:0]      addr_q;
  logic [1:0]       op_q;
  logic [15:0]      rdata_q, rd_sh;
  logic [CNT_W-1:0] per_q, cnt, cnt_nx, half, prod, per_new;
  logic [DIV_W-1:0] dsel, eff;
  logic [DVD_W-1:0] vsel;
  logic [5:0]       bitn;
  logic [63:0]      sh;
  logic             last;
  logic             unused_wdata;

  wire busy    = (st == S_RUN);
  wire c45     = param_q[21];
  wire [4:0] phy = param_q[20:16];
  wire wr_ctrl = reg_wr && (reg_addr == A_CTRL);
  wire start   = wr_ctrl && (st == S_IDLE) && (reg_wdata == 32'd1 || reg_wdata == 32'd2);
  wire rdframe = (op_q == 2'd2) && last;
  wire bit_end = (cnt == per_q - CNT_W'(1));

  assign unused_wdata = ^reg_wdata;

  assign dsel    = param_q[25] ? div_int : div_ext;
  assign vsel    = param_q[25] ? dvd_int : dvd_ext;
  assign eff     = (dsel == '0) ? DIV_W'(1) : dsel;
  assign prod    = CNT_W'(eff) * (CNT_W'(vsel) + CNT_W'(1));
  assign per_new = (prod < CNT_W'(2)) ? CNT_W'(2) : prod;
  assign half    = per_q >> 1;
  assign cnt_nx  = bit_end ? '0 : cnt + CNT_W'(1);

  function automatic logic [63:0] mk(input logic [1:0] s, input logic [1:0] o,
                                     input logic [4:0] a, input logic [4:0] b,
                                     input logic [15:0] d);
    return {32'hFFFF_FFFF, s, o, a, b, 2'b10, d};
  endfunction

  wire [63:0] f_c22_wr = mk(2'b01, 2'b01, phy, addr_q[4:0], param_q[15:0]);
  wire [63:0] f_c22_rd = mk(2'b01, 2'b10, phy, addr_q[4:0], 16'hFFFF);
  wire [63:0] f_c45_ad = mk(2'b00, 2'b00, phy, addr_q[20:16], addr_q[15:0]);
  wire [63:0] f_c45_dt = (op_q == 2'd2) ? mk(2'b00, 2'b11, phy, addr_q[20:16], 16'hFFFF)
                                        : mk(2'b00, 2'b01, phy, addr_q[20:16], param_q[15:0]);

  assign mdio_o    = sh[63];
  assign mdio_oe   = busy && !(rdframe && bitn >= 6'd47);
  assign bus_int   = param_q[25];
  assign bus_idx   = param_q[24:22];
  assign ext_block = scan_ovr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_ext  <= RATE_RST[DIV_W-1:0];
      div_int  <= RATE_RST[DIV_W-1:0];
      dvd_ext  <= RATE_RST[16 +: DVD_W];
      dvd_int  <= RATE_RST[16 +: DVD_W];
      scan_ovr <= 1'b0;
      param_q  <= '0;
      addr_q   <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        A_RATE_EXT: begin div_ext <= reg_wdata[DIV_W-1:0]; dvd_ext <= reg_wdata[16 +: DVD_W]; end
        A_RATE_INT: begin div_int <= reg_wdata[DIV_W-1:0]; dvd_int <= reg_wdata[16 +: DVD_W]; end
        A_SCAN:     scan_ovr <= reg_wdata[28];
        A_PARAM:    if (!busy) param_q <= reg_wdata[25:0];
        A_ADDR:     if (!busy) addr_q <= reg_wdata[20:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; op_q <= '0; per_q <= CNT_W'(2); cnt <= '0; bitn <= '0;
      sh <= '0; last <= 1'b0; mdc <= 1'b0; rd_sh <= '0; rdata_q <= '0;
    end else if (wr_ctrl && reg_wdata == 32'd0) begin
      st <= S_IDLE; op_q <= '0; mdc <= 1'b0;
    end else if (start) begin
      st    <= S_RUN;
      op_q  <= reg_wdata[1:0];
      per_q <= per_new;
      cnt   <= '0;
      bitn  <= '0;
      mdc   <= 1'b0;
      last  <= !c45;
      sh    <= c45 ? f_c45_ad : (reg_wdata[1] ? f_c22_rd : f_c22_wr);
    end else if (busy) begin
      cnt <= cnt_nx;
      mdc <= (cnt_nx >= half);
      if (cnt_nx == half && rdframe && bitn >= 6'd48) rd_sh <= {rd_sh[14:0], mdio_i};
      if (bit_end) begin
        if (bitn == 6'd63) begin
          bitn <= '0;
          if (last) begin
            st <= S_DONE;
            if (op_q == 2'd2) rdata_q <= rd_sh;
          end else begin
            last <= 1'b1;
            sh   <= f_c45_dt;
          end
        end else begin
          bitn <= bitn + 6'd1;
          sh   <= sh << 1;
        end
      end
    end
  end

  always_comb begin
    case (reg_addr)
      A_RATE_EXT: reg_rdata = 32'(div_ext) | (32'(dvd_ext) << 16);
      A_RATE_INT: reg_rdata = 32'(div_int) | (32'(dvd_int) << 16);
      A_SCAN:     reg_rdata = 32'(scan_ovr) << 28;
      A_PARAM:    reg_rdata = 32'(param_q);
      A_RDATA:    reg_rdata = 32'(rdata_q);
      A_ADDR:     reg_rdata = 32'(addr_q);
      A_CTRL:     reg_rdata = 32'(op_q);
      A_STAT:     reg_rdata = 32'(st == S_DONE);
      default:    reg_rdata = '0;
    endcase
  end

  assert_start_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DONE && wr_ctrl && reg_wdata != 32'd0) |=> (st == S_DONE));

  assert_mdio_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy)) |-> (!mdc && !mdio_oe));

  assert_clear_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && reg_wdata == 32'd0) |=> (st == S_IDLE && !mdc && !mdio_oe));

  assert_param_lock_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_wr && (reg_addr == A_PARAM || reg_addr == A_ADDR)) |=> ($stable(param_q) && $stable(addr_q)));
endmodule

// File: tb/mdio_mgmt_master_tb_top.sv
module mdio_mgmt_master_tb_top;
  localparam logic [11:0] RX = 12'h000, RI = 12'h004, SC = 12'h008, PA = 12'h23C,
                          RD = 12'h240, AD = 12'h244, CT = 12'h248, ST = 12'h24C;

  logic clk = 0, rst_n = 0, reg_wr = 0, mdio_i = 1'b1;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic mdc, mdio_o, mdio_oe, bus_int, ext_block;
  logic [2:0] bus_idx;

  int total = 0, bad = 0, cyc = 0, mon = 0, per_exp = 2, rises = 0, last_rise = 0;
  int exp_q[$];
  string freq = "R4";
  logic pm = 0, po = 0, poe = 0;
  logic [15:0] phy_val = '0;

  mdio_mgmt_master dut_i (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .mdio_i(mdio_i), .bus_int(bus_int), .bus_idx(bus_idx), .ext_block(ext_block));

  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic push_frame(input logic [1:0] s, input logic [1:0] o, input logic [4:0] a,
                            input logic [4:0] b, input bit rdf, input logic [15:0] d);
    repeat (32) exp_q.push_back(1);
    exp_q.push_back(int'(s[1])); exp_q.push_back(int'(s[0]));
    exp_q.push_back(int'(o[1])); exp_q.push_back(int'(o[0]));
    for (int i = 4; i >= 0; i--) exp_q.push_back(int'(a[i]));
    for (int i = 4; i >= 0; i--) exp_q.push_back(int'(b[i]));
    exp_q.push_back(1);
    exp_q.push_back(rdf ? 2 : 0);
    for (int i = 15; i >= 0; i--) exp_q.push_back(rdf ? 2 : int'(d[i]));
  endtask

  // Monitor: behavioural reference for MDC timing, bit stream and PHY response
  always @(negedge clk) begin
    cyc++;
    if (mon == 0) chk("R8 idle mdc/oe", {30'b0, mdc, mdio_oe}, 0);
    else if (mon == 1) begin
      if (mdc && pm) chk("R7 hold while mdc high", {30'b0, mdio_o, mdio_oe}, {30'b0, po, poe});
      if (mdc && !pm) begin
        if (rises > 0) chk("R6 period", cyc - last_rise, per_exp);
        last_rise = cyc;
        if (exp_q.size() == 0) chk({freq, " extra bit"}, 1, 0);
        else begin
          int e;
          e = exp_q.pop_front();
          if (e == 2) chk("R8 released", {31'b0, mdio_oe}, 0);
          else chk({freq, " frame bit"}, {30'b0, mdio_oe, mdio_o}, {30'b0, 1'b1, e[0]});
        end
        rises++;
      end
      if (!mdc && pm) begin
        int idx;
        chk("R6 high time", cyc - last_rise, per_exp - per_exp / 2);
        idx = rises % 64;
        if (idx >= 48) mdio_i = phy_val[63 - idx];
      end
    end
    pm = mdc; po = mdio_o; poe = mdio_oe;
  end

  task automatic run_op(input bit rdo, input bit c45, input bit isel, input logic [4:0] phy,
                        input logic [20:0] adr, input logic [15:0] dat, input logic [15:0] pv,
                        input int per, input bit clear, input bit meddle);
    logic [31:0] v, pw;
    pw = {6'b0, isel, 3'd1, c45, phy, dat};
    wr(PA, pw); wr(AD, 32'(adr));
    exp_q.delete();
    if (!c45) push_frame(2'b01, rdo ? 2'b10 : 2'b01, phy, adr[4:0], rdo, dat);
    else begin
      push_frame(2'b00, 2'b00, phy, adr[20:16], 0, adr[15:0]);
      push_frame(2'b00, rdo ? 2'b11 : 2'b01, phy, adr[20:16], rdo, dat);
    end
    per_exp = per; rises = 0; phy_val = pv; freq = c45 ? "R5" : "R4"; mon = 1;
    wr(CT, rdo ? 32'd2 : 32'd1);
    if (meddle) begin
      repeat (20) @(negedge clk);
      wr(PA, 32'h0); wr(AD, 32'h1F_FFFF);
    end
    v = 0;
    for (int i = 0; i < 3000; i++) begin rd(ST, v); if (v[0]) break; end
    mon = 0;
    chk("R10 done set", v, 1);
    chk({freq, " bits left"}, exp_q.size(), 0);
    chk({freq, " rise count"}, rises, c45 ? 128 : 64);
    if (rdo) begin rd(RD, v); chk("R9 read data", v, 32'(pv)); end
    if (meddle) begin
      rd(PA, v); chk("R11 param kept", v, pw);
      rd(AD, v); chk("R11 addr kept", v, 32'(adr));
    end
    if (clear) begin wr(CT, 0); rd(ST, v); chk("R10 done cleared", v, 0); end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL R10 watchdog act=hung exp=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset values
    rd(RX, v); chk("R1 rate ext", v, 32'h0001_0002);
    rd(RI, v); chk("R1 rate int", v, 32'h0001_0002);
    rd(SC, v); chk("R1 scan", v, 0);
    rd(PA, v); chk("R1 param", v, 0);
    rd(RD, v); chk("R1 rdata", v, 0);
    rd(AD, v); chk("R1 addr", v, 0);
    rd(CT, v); chk("R1 ctrl", v, 0);
    rd(ST, v); chk("R1 status", v, 0);
    // R2 routing outputs
    wr(PA, (32'd1 << 25) | (32'd5 << 22));
    @(negedge clk); chk("R2 bus_int", {31'b0, bus_int}, 1); chk("R2 bus_idx", {29'b0, bus_idx}, 5);
    wr(SC, 32'h1000_0000);
    @(negedge clk); chk("R2 ext_block", {31'b0, ext_block}, 1);
    rd(SC, v); chk("R2 scan readback", v, 32'h1000_0000);
    wr(PA, 32'd2 << 22);
    @(negedge clk); chk("R2 bus_int low", {31'b0, bus_int}, 0); chk("R2 bus_idx 2", {29'b0, bus_idx}, 2);
    // R6 rate setups: internal odd period 3, external divisor 0 clamps to 2
    wr(RI, 32'h0000_0003);
    wr(RX, 32'h0000_0000);
    run_op(0, 0, 1, 5'h11, 21'h0000A, 16'hBEEF, 16'h0, 3, 1, 0);
    run_op(1, 0, 0, 5'h03, 21'h0001F, 16'h0, 16'hA5C3, 2, 1, 0);
    // external period from dividend: 1 * (3 + 1) = 4
    wr(RX, 32'h0003_0000);
    run_op(0, 1, 0, 5'h07, {5'h1E, 16'h8001}, 16'h0F0F, 16'h0, 4, 1, 0);
    run_op(1, 1, 1, 5'h1C, {5'h01, 16'h0007}, 16'h0, 16'h1234, 3, 0, 0);
    // R3 start while done is still set is ignored
    wr(CT, 32'd2);
    repeat (10) @(negedge clk);
    rd(ST, v); chk("R3 done held", v, 1);
    rd(RD, v); chk("R3 rdata held", v, 32'h1234);
    wr(CT, 0);
    rd(ST, v); chk("R10 cleared", v, 0);
    // R3 unsupported opcode
    wr(CT, 32'd3);
    repeat (10) @(negedge clk);
    rd(ST, v); chk("R3 opcode 3 no done", v, 0);
    rd(CT, v); chk("R3 opcode 3 not taken", v, 0);
    // R11 writes during a run are dropped
    run_op(0, 0, 0, 5'h15, 21'h00015, 16'h6A39, 16'h0, 4, 1, 1);
    // R10 abort in mid-frame
    wr(PA, {6'b0, 1'b1, 3'd0, 1'b0, 5'h01, 16'h0});
    wr(AD, 32'h2);
    mon = 2;
    wr(CT, 32'd2);
    repeat (30) @(negedge clk);
    wr(CT, 0);
    @(negedge clk);
    chk("R10 abort mdc", {31'b0, mdc}, 0);
    chk("R10 abort oe", {31'b0, mdio_oe}, 0);
    rd(ST, v); chk("R10 abort status", v, 0);
    mon = 0;
    repeat (5) @(negedge clk);
    run_op(1, 0, 1, 5'h01, 21'h00002, 16'h0, 16'h0001, 3, 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule